// File: doc/BRIEF.md
# Bulk-Clear Static Memory

This block is a synchronous model of a 1024-word, 4-bit-wide static memory. Input data and output data travel on separate 4-bit buses. Four active-low strobes control it: select, write, output enable and clear. Every control and data input is sampled on the rising clock edge. A read result appears on the output register one cycle after the read is sampled. In place of a three-state pin, the output carries a separate drive-enable flag.

The distinguishing operation is a bulk clear, which zeroes the entire array in two clock cycles. The select strobe gates the clear, so one clear line can be routed to many devices and only the selected ones wipe their contents. Internally the storage is a 64 x 64 bit matrix, with 16 words per row. Rows are picked by the upper six address bits and words within a row by the lower four. The clear wipes the lower 32 rows on its first cycle and the upper 32 rows on its second.

Top module: `sram_bulkclr`

## Requirements
- R1: With cs_n=0, we_n=0 and clr_n=1 sampled at an edge (and no clear in its second cycle), din is stored at addr and every other word is unchanged.
- R2: With cs_n=0, oe_n=0, we_n=1 and clr_n=1 sampled at an edge (and no clear in its second cycle), dout shows the stored word and dout_en is 1 during the following cycle. dout_en is never 1 in any other situation.
- R3: If cs_n=1 is sampled at an edge, dout_en is 0 during the following cycle.
- R4: If oe_n=1 is sampled at an edge, dout_en is 0 during the following cycle.
- R5: If we_n=0 is sampled at an edge, dout_en is 0 during the following cycle.
- R6: If clr_n=0 is sampled at an edge, dout_en is 0 during the following cycle.
- R7: Whenever dout_en is 0, dout is 0.
- R8: Sampling cs_n=0 and clr_n=0 at an edge starts a clear. Addresses 0 to 511 are zeroed on that edge and addresses 512 to 1023 on the next one. A read sampled two edges after the start returns 0 for every address.
- R9: Any write or read sampled on the second edge of a clear is ignored. Nothing is stored, and dout_en is 0 afterwards.
- R10: clr_n=0 has no effect on the contents while cs_n=1.
- R11: If clr_n=0 and we_n=0 are sampled together with cs_n=0, the clear takes place and the write does not.
- R12: rst_n=0 forces dout_en=0 and dout=0 and abandons any clear in progress. Stored words that the clear had not yet reached keep their values.
- R13: Holding clr_n=0 with cs_n=0 for more than two cycles leaves the whole array zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| cs_n | input | 1 | Active-low device select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low bulk-clear request |
| addr | input | 10 | Word address; bits 9:4 pick the row, bits 3:0 the word in the row |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, 0 when not driven |
| dout_en | output | 1 | High when dout carries valid read data |

## Verification
The clear can coincide with an ordinary access in two ways. A write strobe can arrive on the same edge as the clear request, and a read or write can arrive on the clear's second edge. The bench creates both cases on purpose: first it stores nonzero data in each half of the array, then it issues the overlapping access. It judges the result by reading the affected addresses back afterwards and by checking that no drive-enable appears for an access that was swallowed. A reset that arrives after the clear's first edge is also covered: the upper half must keep its data.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int unsigned SBC_ADDR_W = 10;
    localparam int unsigned SBC_DATA_W = 4;
    localparam int unsigned SBC_ROWS   = 64;

    // Phase of the two-cycle wipe
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_UPPER = 1'b1
    } clr_phase_e;

    // Access requested by the strobes in one cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    // Priority: deselect, then clear, then write, then read
    function automatic op_e decode_op(input logic cs_n, input logic we_n,
                                      input logic oe_n, input logic clr_n);
        if (cs_n)  return OP_NONE;
        if (!clr_n) return OP_CLEAR;
        if (!we_n) return OP_WRITE;
        if (!oe_n) return OP_READ;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic clr_n,
    output logic wr_go,
    output logic rd_go,
    output logic wipe_lo,
    output logic wipe_hi
);

    typedef struct packed {
        clr_phase_e phase;
    } seq_t;

    seq_t st_d, st_q;
    op_e  op;

    always_comb begin
        op      = decode_op(cs_n, we_n, oe_n, clr_n);
        st_d    = st_q;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        wipe_lo = 1'b0;
        wipe_hi = 1'b0;
        if (st_q.phase == PH_UPPER) begin
            // second wipe cycle: every access is swallowed
            wipe_hi    = 1'b1;
            st_d.phase = PH_IDLE;
        end else begin
            unique case (op)
                OP_CLEAR: begin
                    wipe_lo    = 1'b1;
                    st_d.phase = PH_UPPER;
                end
                OP_WRITE: wr_go = 1'b1;
                OP_READ:  rd_go = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 4,
    parameter int unsigned ROWS   = 64
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic              wipe_lo,
    input  logic              wipe_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_word
);

    localparam int unsigned ROW_W  = (DATA_W << ADDR_W) / ROWS;
    localparam int unsigned WPR    = ROW_W / DATA_W;
    localparam int unsigned COL_AW = $clog2(WPR);
    localparam int unsigned ROW_AW = ADDR_W - COL_AW;
    localparam int unsigned HALF   = ROWS / 2;

    logic [ROW_AW-1:0] row_sel;
    logic [COL_AW-1:0] col_sel;
    logic [ROW_W-1:0]  row_q [ROWS];
    logic [ROW_W-1:0]  row_d [ROWS];

    assign row_sel = addr[ADDR_W-1:COL_AW];
    assign col_sel = addr[COL_AW-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic wipe_row;
        if (r < HALF) begin : g_lo
            assign wipe_row = wipe_lo;
        end else begin : g_hi
            assign wipe_row = wipe_hi;
        end

        always_comb begin
            row_d[r] = row_q[r];
            if (wipe_row) begin
                row_d[r] = '0;
            end else if (wr_go && (row_sel == ROW_AW'(r))) begin
                row_d[r][col_sel*DATA_W +: DATA_W] = din;
            end
        end

        always_ff @(posedge clk) begin
            row_q[r] <= row_d[r];
        end
    end

    assign rd_word = row_q[row_sel][col_sel*DATA_W +: DATA_W];

endmodule

// File: rtl/sbc_rdport.sv
module sbc_rdport #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              en;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.en   = rd_go;
        rd_d.data = rd_go ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign dout    = rd_q.data;
    assign dout_en = rd_q.en;

endmodule

// File: rtl/sram_bulkclr.sv
module sram_bulkclr #(
    parameter int unsigned ADDR_W = sbc_pkg::SBC_ADDR_W,
    parameter int unsigned DATA_W = sbc_pkg::SBC_DATA_W,
    parameter int unsigned ROWS   = sbc_pkg::SBC_ROWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic wr_go;
    logic rd_go;
    logic wipe_lo;
    logic wipe_hi;
    logic [DATA_W-1:0] rd_word;

    sbc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .clr_n   (clr_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wipe_lo (wipe_lo),
        .wipe_hi (wipe_hi)
    );

    sbc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ROWS   (ROWS)
    ) u_array (
        .clk     (clk),
        .wr_go   (wr_go),
        .wipe_lo (wipe_lo),
        .wipe_hi (wipe_hi),
        .addr    (addr),
        .din     (din),
        .rd_word (rd_word)
    );

    sbc_rdport #(
        .DATA_W (DATA_W)
    ) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (rd_go),
        .rd_word (rd_word),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              clr_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    AST_EN_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!cs_n && !oe_n && we_n && clr_n)); // R2

    AST_DESEL_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_en); // R3

    AST_OE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en); // R4

    AST_WE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dout_en); // R5

    AST_CLR_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !dout_en); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R7

endmodule

bind sram_bulkclr sbc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .clr_n   (clr_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/sim_sram_bulkclr.sv
module sim_sram_bulkclr;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int DW         = 4;
    localparam int WORDS      = 1 << AW;
    localparam int LIMIT      = 100000;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n  = 1'b1;
    logic          we_n  = 1'b1;
    logic          oe_n  = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] din   = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bulkclr u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .clr_n   (clr_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    logic [DW-1:0] ref_mem [WORDS];
    logic          tb_busy = 1'b0;
    int            checks  = 0;
    int            errors  = 0;
    bit            reported = 1'b0;

    logic [DW:0] exp_q [$];
    string       tag_q [$];
    logic [DW:0] mon_exp;
    string       mon_tag;

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        return DW'(a * 7 + seed + (a >> 4));
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: {en,data} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Driver: one access per cycle; predicted output is queued for the monitor
    task automatic op(input logic c, input logic w, input logic o, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
        logic          e;
        logic [DW-1:0] v;
        @(negedge clk);
        cs_n  = c;
        we_n  = w;
        oe_n  = o;
        clr_n = r;
        addr  = a;
        din   = d;
        e = 1'b0;
        v = '0;
        if (tb_busy) begin
            for (int i = WORDS/2; i < WORDS; i++) ref_mem[i] = '0;
            tb_busy = 1'b0;
        end else if (!c && !r) begin
            for (int i = 0; i < WORDS/2; i++) ref_mem[i] = '0;
            tb_busy = 1'b1;
        end else if (!c && !w) begin
            ref_mem[a] = d;
        end else if (!c && !o) begin
            e = 1'b1;
            v = ref_mem[a];
        end
        @(posedge clk);
        #1;
        exp_q.push_back({e, v});
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        op(1'b0, 1'b0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        op(1'b0, 1'b1, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst_n   = 1'b0;
        cs_n    = 1'b1;
        we_n    = 1'b1;
        oe_n    = 1'b1;
        clr_n   = 1'b1;
        tb_busy = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check({dout_en, dout} == '0, "R12 reset state", {dout_en, dout}, '0);
        rst_n = 1'b1;
    endtask

    // Monitor: compares each queued prediction one cycle after it was driven
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            check({dout_en, dout} === mon_exp, mon_tag, {dout_en, dout}, mon_exp);
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        do_reset();

        // R1 / R5: fill every word (write strobe keeps outputs undriven)
        for (int a = 0; a < WORDS; a++) wr(AW'(a), pat(a, 3), "R1 R5 fill");
        for (int a = 0; a < WORDS; a++) rd(AW'(a), "R1 R2 full readback");

        // R1 / R2: random write and read-back
        for (int k = 0; k < 200; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom % WORDS);
            wr(ra, DW'($urandom), "R1 random write");
            rd(ra, "R2 random read");
            rd(AW'($urandom % WORDS), "R2 random read other");
        end

        // Undriven-output conditions, each followed by a plain read
        op(1'b0, 1'b1, 1'b1, 1'b1, AW'(3), '0, "R4 oe high");
        op(1'b1, 1'b1, 1'b0, 1'b1, AW'(3), '0, "R3 deselected");
        op(1'b0, 1'b0, 1'b0, 1'b1, AW'(3), 4'hC, "R5 we low with oe low");
        rd(AW'(3), "R7 read after idle cycles");

        // R10 / R6: clear request while deselected does nothing
        op(1'b1, 1'b1, 1'b0, 1'b0, AW'(0), '0, "R6 R10 unselected clear");
        op(1'b1, 1'b1, 1'b0, 1'b0, AW'(0), '0, "R6 R10 unselected clear");
        for (int a = 0; a < WORDS; a += 31) rd(AW'(a), "R10 contents kept");

        // R11: clear and write sampled together
        wr(AW'(5), 4'h7, "R1 setup");
        wr(AW'(600), 4'h3, "R1 setup");
        op(1'b0, 1'b0, 1'b1, 1'b0, AW'(600), 4'hF, "R6 R11 clear with write");
        op(1'b0, 1'b1, 1'b0, 1'b1, AW'(600), '0, "R9 read in second clear cycle");
        rd(AW'(600), "R11 no write");
        rd(AW'(5), "R8 R11 lower half zero");

        // R9: write in the second clear cycle is dropped
        wr(AW'(700), 4'h9, "R1 setup");
        wr(AW'(10), 4'h6, "R1 setup");
        op(1'b0, 1'b1, 1'b1, 1'b0, AW'(0), '0, "R6 R8 clear start");
        wr(AW'(700), 4'h5, "R9 write in second clear cycle");
        rd(AW'(700), "R9 write ignored");
        rd(AW'(10), "R8 lower half zero");

        // R12: reset abandons a clear after its first edge
        wr(AW'(900), 4'hA, "R1 setup");
        wr(AW'(100), 4'hB, "R1 setup");
        op(1'b0, 1'b1, 1'b1, 1'b0, AW'(0), '0, "R6 R8 clear start");
        do_reset();
        rd(AW'(900), "R12 upper half kept");
        rd(AW'(100), "R12 lower half cleared");

        // R13 / R8: refill, hold clear low four cycles, sweep all words
        for (int a = 0; a < WORDS; a++) wr(AW'(a), pat(a, 9) | 4'h1, "R1 refill");
        for (int k = 0; k < 4; k++) op(1'b0, 1'b1, 1'b1, 1'b0, AW'(0), '0, "R6 R13 held clear");
        for (int a = 0; a < WORDS; a++) rd(AW'(a), "R8 R13 all zero");

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule